// File: doc/BRIEF.md
# SPI Master/Slave Port

This block is a byte-wide serial peripheral interface port that can act as the clocking end of a link (master) or as the clocked end (slave). Software sets it up through a small register window: a control register, a status register and a data register. One control register picks the role, the bit order, the clock polarity, the clock phase, the master clock rate and the interrupt enable. A port enable bit gates every transfer in either role.

As master, a write to the data register starts one byte. The port drives the serial clock and the outgoing data line, samples the incoming line, and then places the received byte in a read register and raises a completion flag. As slave, it follows an external serial clock while the select line is low and drives its data line only while selected. If the select line is set up as an input and goes low while the port is master, the port drops to slave and raises the completion flag. It stays slave until software sets master again. An interrupt line reports the flag when the local enable and a chip-wide enable are both set.

The master sequencer has three states. IDLE goes to RUN on a data write in master mode. RUN goes to HOLD on the sixteenth clock edge. HOLD returns to IDLE after one half period. RUN and HOLD also go straight back to IDLE when the port stops being an enabled master, whether through disable, a role change or a mode fault.

Top module: `spi_port`

## Requirements
- R1: Register window: address 0 is control, 1 is status (completion flag in bit 7, other bits 0), 2 is data. Control bits are, from bit 7 down: interrupt enable, port enable, LSB-first, master, clock polarity, clock phase, rate bits 1:0. All are read/write and reset to 0, and all outputs and output enables are 0 after reset.
- R2: With port enable 0, no SCK/MOSI/MISO output enable is asserted, no transfer starts and the completion flag is not set, even under data writes or external clocking.
- R3: With LSB-first 1, bit 0 of a byte is on the wire first; with 0, bit 7 is first. This holds for both directions and both roles.
- R4: In master mode, a data write while idle makes 16 SCK edges. After the last one, the byte sampled from MISO can be read at address 2 and the completion flag is 1.
- R5: SCK rests at the clock polarity level whenever no master transfer runs. In a master transfer the edges are 2, 8, 32 or 64 system clocks apart for rate 0, 1, 2 or 3.
- R6: With clock phase 0, data is sampled on the leading (odd-numbered) SCK edges and changed on the trailing ones. With clock phase 1, data is changed on the leading edges and sampled on the trailing ones.
- R7: In slave mode with SS low, the port shifts on the external SCK and sets the flag after 16 edges, with the MOSI byte readable at address 2. A data write loads the transmit byte only while SS is high; a write made while SS is low is ignored.
- R8: In slave mode, MISO output enable is 1 only while SS is low. SS high resets the edge count, so a byte cut short leaves no trace in the next one.
- R9: With SS configured as input, SS low in enabled master mode clears the master bit and sets the completion flag. The master bit stays 0 until software writes it to 1.
- R10: The interrupt output is 1 exactly when the completion flag, the interrupt enable bit and the global enable input are all 1.
- R11: The completion flag clears only on a data register access that follows a status read made while the flag was 1. A data access with no such status read leaves the flag set.
- R12: A data write during an active master transfer is ignored, and the byte on MOSI is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives flag clearing) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| gie | input | 1 | Chip-wide interrupt enable |
| ss_is_input | input | 1 | SS pin is configured as input (enables mode-fault detection) |
| sck_i | input | 1 | Serial clock from the pin (slave) |
| sck_o | output | 1 | Serial clock to the pin (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line from the pin (slave receive) |
| mosi_o | output | 1 | Master-out line to the pin |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line from the pin (master receive) |
| miso_o | output | 1 | Master-in line to the pin |
| miso_oe | output | 1 | Master-in output enable |
| ss_n_i | input | 1 | Active-low slave select from the pin |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the bound checker ensures the following. A disabled port drives no pins. SCK rests at the polarity level outside RUN and HOLD. MISO is released while SS is high. A qualified SS low always clears master and sets the flag, and every completed byte raises the flag. The port never drives as master and slave at once. Only the bench's scenarios can show the bytes that actually cross the wire, how SCK edges are spaced for each rate, the sample and change edges for every polarity, phase and order combination, the ignored writes, and the order of accesses that clears the flag.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int DATA_W  = 8;
    localparam int EDGES   = 2 * DATA_W;
    localparam int TMR_W   = 7;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_RUN  = 2'd1,
        MS_HOLD = 2'd2
    } mseq_state_t;

    typedef struct packed {
        logic       irq_en;
        logic       en;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    // Half SCK period in system clocks for each rate code.
    function automatic logic [TMR_W-1:0] half_cycles(input logic [1:0] rate);
        logic [TMR_W-1:0] h;
        unique case (rate)
            2'd0: h = TMR_W'(2);
            2'd1: h = TMR_W'(8);
            2'd2: h = TMR_W'(32);
            default: h = TMR_W'(64);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q  <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            stage_q  <= async_in;
            sync_out <= stage_q;
        end
    end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         edge_pulse,
    input  logic         lsb_first,
    input  logic         cpha,
    input  logic         sin,
    output logic         sout,
    output logic [W-1:0] rx_word,
    output logic         byte_done
);

    localparam int EDGES = 2 * W;
    localparam int IW    = $clog2(EDGES);

    logic [IW-1:0] idx_q;
    logic [W-1:0]  tx_q;
    logic [W-1:0]  rx_q;
    logic          sample_now;
    logic          shift_now;

    // Phase 0: even edge index samples. Phase 1: odd edge index samples.
    // Phase 1 skips the very first change edge: bit 0 is already on the line.
    assign sample_now = edge_pulse && (idx_q[0] == cpha);
    assign shift_now  = edge_pulse && (idx_q[0] != cpha) && !(cpha && (idx_q == '0));
    assign byte_done  = edge_pulse && (idx_q == IW'(EDGES - 1));
    assign sout       = lsb_first ? tx_q[0] : tx_q[W-1];

    always_comb begin
        rx_word = rx_q;
        if (sample_now) begin
            if (lsb_first) rx_word = {sin, rx_q[W-1:1]};
            else           rx_word = {rx_q[W-2:0], sin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            tx_q  <= '0;
            rx_q  <= '0;
        end else begin
            rx_q <= rx_word;
            if (load) begin
                tx_q  <= load_data;
                idx_q <= '0;
            end else begin
                if (clear)           idx_q <= '0;
                else if (edge_pulse) idx_q <= idx_q + 1'b1;
                if (shift_now) begin
                    if (lsb_first) tx_q <= {1'b0, tx_q[W-1:1]};
                    else           tx_q <= {tx_q[W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/spi_master_seq.sv
module spi_master_seq
    import spi_port_pkg::*;
#(
    parameter int TW = TMR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [TW-1:0] half_len,
    input  logic          last_edge,
    output logic          edge_pulse,
    output logic          sck_phase,
    output logic          busy
);

    mseq_state_t   state_q, state_d;
    logic [TW-1:0] timer_q;
    logic          timer_hit;

    assign timer_hit = (timer_q == half_len - TW'(1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE: if (start && !abort) state_d = MS_RUN;
            MS_RUN: begin
                if (abort)                        state_d = MS_IDLE;
                else if (edge_pulse && last_edge) state_d = MS_HOLD;
            end
            MS_HOLD: begin
                if (abort || timer_hit) state_d = MS_IDLE;
            end
            default: state_d = MS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy       = (state_q != MS_IDLE);
        edge_pulse = (state_q == MS_RUN) && timer_hit && !abort;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q   <= '0;
            sck_phase <= 1'b0;
        end else begin
            if (state_d != state_q || timer_hit || state_q == MS_IDLE) timer_q <= '0;
            else                                                       timer_q <= timer_q + TW'(1);
            if (state_d == MS_IDLE) sck_phase <= 1'b0;
            else if (edge_pulse)    sck_phase <= ~sck_phase;
        end
    end

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          gie,
    input  logic          ss_is_input,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_n_i,
    output logic          irq
);

    ctrl_t         ctrl_q;
    logic          flag_q;
    logic          arm_q;
    logic [DW-1:0] rdbuf_q;
    logic          sck_prev_q;

    logic          sck_s, mosi_s, ss_s;
    logic          wr_ctrl, wr_data, rd_stat, data_acc;
    logic          is_master, mode_fault, slave_active;
    logic          m_start, m_abort, m_edge, m_phase, m_busy;
    logic          s_edge, s_load;
    logic          sh_edge, sh_load, sh_clear, sh_sin, sh_sout, sh_done;
    logic [DW-1:0] sh_rx;

    spi_port_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sck_i, mosi_i, ss_n_i}),
        .sync_out ({sck_s, mosi_s, ss_s})
    );

    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_data  = reg_wr && (reg_addr == ADDR_DATA);
    assign rd_stat  = reg_rd && (reg_addr == ADDR_STAT);
    assign data_acc = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);

    assign is_master    = ctrl_q.en && ctrl_q.master;
    assign mode_fault   = is_master && ss_is_input && !ss_s;
    assign slave_active = ctrl_q.en && !ctrl_q.master && !ss_s;

    assign m_start  = is_master && wr_data && !m_busy;
    assign m_abort  = !is_master || mode_fault;
    assign s_edge   = slave_active && (sck_s != sck_prev_q);
    assign s_load   = !ctrl_q.master && ss_s && wr_data;

    assign sh_load  = m_start || s_load;
    assign sh_clear = !(is_master || slave_active);
    assign sh_edge  = is_master ? m_edge : s_edge;
    assign sh_sin   = is_master ? miso_i : mosi_s;

    spi_master_seq #(.TW(TMR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (m_start),
        .abort      (m_abort),
        .half_len   (half_cycles(ctrl_q.rate)),
        .last_edge  (sh_done),
        .edge_pulse (m_edge),
        .sck_phase  (m_phase),
        .busy       (m_busy)
    );

    spi_shifter #(.W(DW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (sh_clear),
        .load       (sh_load),
        .load_data  (reg_wdata),
        .edge_pulse (sh_edge),
        .lsb_first  (ctrl_q.lsb_first),
        .cpha       (ctrl_q.cpha),
        .sin        (sh_sin),
        .sout       (sh_sout),
        .rx_word    (sh_rx),
        .byte_done  (sh_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            flag_q     <= 1'b0;
            arm_q      <= 1'b0;
            rdbuf_q    <= '0;
            sck_prev_q <= 1'b1;
        end else begin
            sck_prev_q <= sck_s;
            if (wr_ctrl)    ctrl_q        <= ctrl_t'(reg_wdata[7:0]);
            if (mode_fault) ctrl_q.master <= 1'b0;
            if (sh_done)    rdbuf_q       <= sh_rx;
            if (sh_done || mode_fault)    flag_q <= 1'b1;
            else if (arm_q && data_acc)   flag_q <= 1'b0;
            if (rd_stat && flag_q) arm_q <= 1'b1;
            else if (data_acc)     arm_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = DW'(ctrl_q);
            ADDR_STAT: reg_rdata = DW'({flag_q, 7'b0});
            ADDR_DATA: reg_rdata = rdbuf_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign sck_o   = is_master ? (ctrl_q.cpol ^ m_phase) : ctrl_q.cpol;
    assign sck_oe  = is_master;
    assign mosi_o  = sh_sout;
    assign mosi_oe = is_master;
    assign miso_o  = sh_sout;
    assign miso_oe = slave_active;
    assign irq     = flag_q && ctrl_q.irq_en && gie;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl,
    input logic       flag,
    input logic       busy,
    input logic       done,
    input logic       ss_s,
    input logic       ss_is_input,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       miso_oe
);

    assert_pins_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[6] |-> (!sck_oe && !mosi_oe && !miso_oe && !busy));

    assert_single_role_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(miso_oe && (sck_oe || mosi_oe)));

    assert_done_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag);

    assert_sck_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck_o == ctrl[3]));

    assert_miso_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |-> !miso_oe);

    assert_mode_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[6] && ctrl[4] && ss_is_input && !ss_s) |=> (!ctrl[4] && flag));

endmodule

bind spi_port spi_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl_q),
    .flag        (flag_q),
    .busy        (m_busy),
    .done        (sh_done),
    .ss_s        (ss_s),
    .ss_is_input (ss_is_input),
    .sck_o       (sck_o),
    .sck_oe      (sck_oe),
    .mosi_oe     (mosi_oe),
    .miso_oe     (miso_oe)
);

// File: tb/spi_port_test.sv
module spi_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       gie = 1'b0;
    logic       ss_is_input = 1'b0;
    logic       sck_i = 1'b0;
    logic       sck_o, sck_oe;
    logic       mosi_i = 1'b0;
    logic       mosi_o, mosi_oe;
    logic       miso_i = 1'b0;
    logic       miso_o, miso_oe;
    logic       ss_n_i = 1'b1;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spi_port uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie), .ss_is_input(ss_is_input),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
        .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic wire_bit(input logic [7:0] v, input int j, input logic lsb);
        return lsb ? v[j] : v[7-j];
    endfunction

    task automatic run_master(input logic cpol, input logic cpha, input logic lsb,
                              input logic [1:0] rate, input logic [7:0] tx,
                              input logic [7:0] mp, input bit inject);
        int h; int e; int gap; int bad_gap; int guard;
        logic prev; logic [7:0] got; logic [7:0] rd;
        h = (rate == 2'd3) ? 64 : (2 << (2 * rate));
        got = 8'h00; bad_gap = 0; gap = 0; e = 0; guard = 0;
        reg_write(2'd0, {1'b0, 1'b1, lsb, 1'b1, cpol, cpha, rate});
        miso_i = cpha ? 1'b0 : wire_bit(mp, 0, lsb);
        reg_write(2'd2, tx);
        prev = sck_o;
        while (e < 16 && guard < 5000) begin
            @(negedge clk);
            reg_wr = 1'b0;
            gap++; guard++;
            if (sck_o != prev) begin
                prev = sck_o;
                if (e > 0 && gap != h) bad_gap++;
                gap = 0;
                if ((e % 2) == int'(cpha)) begin
                    got[lsb ? (e/2) : (7 - e/2)] = mosi_o;
                end else if (!cpha && e < 15) begin
                    miso_i = wire_bit(mp, (e + 1) / 2, lsb);
                end else if (cpha) begin
                    miso_i = wire_bit(mp, e / 2, lsb);
                end
                if (inject && e == 3) begin
                    reg_addr = 2'd2; reg_wdata = ~tx; reg_wr = 1'b1;
                end
                e++;
            end
        end
        reg_wr = 1'b0;
        check(bad_gap == 0 && e == 16, "R5 edge spacing/count", bad_gap, 0);
        repeat (h + 3) @(negedge clk);
        check(sck_o == cpol, "R5 SCK rests at polarity", sck_o, cpol);
        check(got == tx, inject ? "R12 MOSI byte kept" : "R3 R6 MOSI byte", got, tx);
        reg_read(2'd1, rd);
        check(rd == 8'h80, "R4 completion flag", rd, 8'h80);
        reg_read(2'd2, rd);
        check(rd == mp, "R4 R6 received MISO byte", rd, mp);
        reg_read(2'd1, rd);
        check(rd == 8'h00, "R11 flag cleared", rd, 8'h00);
    endtask

    task automatic run_slave(input logic cpol, input logic cpha, input logic lsb,
                             input logic [7:0] tx, input logic [7:0] mo);
        logic [7:0] got; logic [7:0] rd;
        got = 8'h00;
        ss_n_i = 1'b1; sck_i = cpol;
        mosi_i = cpha ? 1'b0 : wire_bit(mo, 0, lsb);
        reg_write(2'd0, {1'b0, 1'b1, lsb, 1'b0, cpol, cpha, 2'b00});
        repeat (4) @(negedge clk);
        reg_write(2'd2, tx);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        check(miso_oe == 1'b1, "R8 MISO driven while selected", miso_oe, 1);
        reg_write(2'd2, ~tx);
        for (int e = 0; e < 16; e++) begin
            if ((e % 2) == int'(cpha)) got[lsb ? (e/2) : (7 - e/2)] = miso_o;
            sck_i = ~sck_i;
            if ((e % 2) != int'(cpha)) begin
                if (!cpha && e < 15) mosi_i = wire_bit(mo, (e + 1) / 2, lsb);
                else if (cpha)       mosi_i = wire_bit(mo, e / 2, lsb);
            end
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(got == tx, "R7 R3 slave MISO byte, write while selected ignored", got, tx);
        reg_read(2'd1, rd);
        check(rd == 8'h80, "R7 slave completion flag", rd, 8'h80);
        reg_read(2'd2, rd);
        check(rd == mo, "R7 R6 slave received byte", rd, mo);
        ss_n_i = 1'b1;
        repeat (5) @(negedge clk);
        check(miso_oe == 1'b0, "R8 MISO released when deselected", miso_oe, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state and register access
        reg_read(2'd0, rd);
        check(rd == 8'h00, "R1 control reset", rd, 0);
        reg_read(2'd1, rd);
        check(rd == 8'h00, "R1 status reset", rd, 0);
        check({irq, sck_oe, mosi_oe, miso_oe} == 4'b0, "R1 outputs reset",
              {irq, sck_oe, mosi_oe, miso_oe}, 0);
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, rd);
        check(rd == 8'hFF, "R1 control all ones", rd, 8'hFF);
        reg_write(2'd0, 8'h00);
        reg_read(2'd0, rd);
        check(rd == 8'h00, "R1 control all zeros", rd, 0);

        // R2 disabled port: master bit set, enable clear
        reg_write(2'd0, 8'h10);
        reg_write(2'd2, 8'h3C);
        begin
            int toggles;
            toggles = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (sck_o != 1'b0 || sck_oe || mosi_oe) toggles++;
            end
            check(toggles == 0, "R2 no master activity while disabled", toggles, 0);
        end
        // R2 disabled slave under external clocking
        reg_write(2'd0, 8'h00);
        ss_n_i = 1'b0;
        for (int i = 0; i < 16; i++) begin
            sck_i = ~sck_i;
            repeat (6) @(negedge clk);
        end
        check(miso_oe == 1'b0, "R2 no MISO drive while disabled", miso_oe, 0);
        reg_read(2'd1, rd);
        check(rd == 8'h00, "R2 no flag while disabled", rd, 0);
        ss_n_i = 1'b1; sck_i = 1'b0;
        repeat (4) @(negedge clk);

        // R3 R4 R5 R6 master sweep over every configuration
        for (int cfg = 0; cfg < 32; cfg++) begin
            run_master(cfg[4], cfg[3], cfg[2], cfg[1:0],
                       8'(cfg * 29 + 8'h5A), 8'(8'hC3 ^ (cfg * 13)), 1'b0);
        end

        // R12 data write during a master transfer
        run_master(1'b0, 1'b1, 1'b0, 2'd2, 8'h96, 8'h3E, 1'b1);

        // R8 partial slave byte then a full one
        reg_write(2'd0, 8'h40);
        sck_i = 1'b0;
        repeat (4) @(negedge clk);
        reg_write(2'd2, 8'hF0);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            sck_i = ~sck_i;
            repeat (8) @(negedge clk);
        end
        ss_n_i = 1'b1;
        repeat (5) @(negedge clk);
        reg_read(2'd1, rd);
        check(rd == 8'h00, "R8 partial byte leaves no flag", rd, 0);

        // R7 R8 slave sweep
        for (int cfg = 0; cfg < 8; cfg++) begin
            run_slave(cfg[2], cfg[1], cfg[0], 8'(8'h1D + cfg * 41), 8'(8'hB7 ^ (cfg * 19)));
        end

        // R9 mode fault
        ss_is_input = 1'b1; ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        reg_write(2'd0, 8'h50);
        reg_read(2'd0, rd);
        check(rd == 8'h50, "R9 master set before fault", rd, 8'h50);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        reg_read(2'd0, rd);
        check(rd == 8'h40, "R9 master bit cleared by fault", rd, 8'h40);
        check(sck_oe == 1'b0, "R9 SCK released after fault", sck_oe, 0);

        // R10 interrupt gating (flag set by the fault)
        for (int ie = 0; ie < 2; ie++) begin
            for (int g = 0; g < 2; g++) begin
                reg_write(2'd0, {ie[0], 1'b1, 6'b0});
                gie = g[0];
                @(negedge clk);
                check(irq == (ie[0] && g[0]), "R10 irq gating", irq, ie[0] && g[0]);
            end
        end

        // R11 clear sequence
        reg_read(2'd2, rd);
        @(negedge clk);
        check(irq == 1'b1, "R11 data read alone keeps flag", irq, 1);
        reg_read(2'd1, rd);
        check(rd == 8'h80, "R9 fault sets flag", rd, 8'h80);
        reg_read(2'd2, rd);
        @(negedge clk);
        check(irq == 1'b0, "R11 status then data clears flag", irq, 0);
        gie = 1'b0;

        // R9 master stays cleared until rewritten
        reg_write(2'd0, 8'h50);
        repeat (5) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (5) @(negedge clk);
        reg_read(2'd0, rd);
        check(rd == 8'h40, "R9 master stays cleared", rd, 8'h40);
        reg_write(2'd0, 8'h50);
        reg_read(2'd0, rd);
        check(rd == 8'h50, "R9 master set again by write", rd, 8'h50);
        ss_is_input = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule